// File: doc/BRIEF.md
# Prescaled Multi-Mode Compare Timer

This block is a 24-bit up-counting timer driven either by the system clock through an 8-bit divider or by rising edges on an external event pin. On each count step the counter is compared with a programmable compare value. What happens on a match depends on the selected mode. The timer can stop and disarm itself, restart from zero, restart from zero while inverting a square-wave output, or keep counting while only raising the flag.

Control arrives as plain register-style levels and one-cycle write pulses: an enable write, a software reset, and a write-one-to-clear for the interrupt flag. A mirror register exposes the live count while its load enable is set and freezes while it is clear. The interrupt flag stays set until software clears it.

Top module: `ptimer_top`

## Requirements
- R1: After `rst_n` is low, `active`, `cnt_data`, `irq` and `tout` are all 0.
- R2: With `evt_mode`=0 the counter advances once every `presc`+1 clock cycles while enabled, so `presc`=0 gives one step per cycle.
- R3: A `sw_rst` pulse zeroes the divider and the counter and clears the enable bit on the next edge, and it overrides an enable write in the same cycle.
- R4: `active` is 1 exactly while the enable bit is set, and the counter does not move while it is 0.
- R5: With `evt_mode`=1 the counter advances once for each rising edge of `evt_in` after a two-flop synchronizer, and the clock divider has no effect.
- R6: While `load_en`=1 the `cnt_data` output takes the count one cycle later; while `load_en`=0 it holds its value.
- R7: Mode 2'b01 (periodic): when a step would make the count equal to `cmp`, the counter returns to 0 and the flag is raised.
- R8: Mode 2'b10 (toggle): the behaviour of R7 applies, and `tout` inverts at each match, giving a 50% duty-cycle square wave. In any other mode `tout` does not change.
- R9: Mode 2'b11 (continuous): a match raises the flag but the counter keeps counting upward and wraps from 0xFFFFFF to 0.
- R10: Mode 2'b00 (one-shot): at the match the counter returns to 0, the flag is raised and the enable bit clears, so `active` falls.
- R11: `irq` is set on a match only when `irq_en`=1. It then stays set until an `irq_clr` pulse. A match in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| sw_rst | input | 1 | Software reset pulse |
| mode | input | 2 | Mode: 00 one-shot, 01 periodic, 10 toggle, 11 continuous |
| presc | input | 8 | Clock divide value minus one |
| cmp | input | 24 | Compare value |
| irq_en | input | 1 | Allows a match to set the flag |
| irq_clr | input | 1 | Write-one-to-clear pulse for the flag |
| load_en | input | 1 | Lets the mirror register follow the count |
| evt_mode | input | 1 | Selects the external pin as count source |
| evt_in | input | 1 | External event pin (asynchronous) |
| active | output | 1 | Timer running status |
| cnt_data | output | 24 | Mirrored count value |
| irq | output | 1 | Sticky match flag |
| tout | output | 1 | Toggle-mode square-wave output |

## Verification
A wrong divider phase or a missed step shows on `cnt_data` one cycle after the faulty edge, because the mirror follows the count with a single register of delay. The error then persists as a constant offset. A bad match decision appears on `irq`, `tout` or `active` in the same cycle the counter should have wrapped, and it also shifts every later count value. The bench therefore checks the count, the flag, the toggle level and the status together at chosen edge numbers. Event counting is checked only after the synchronizer latency has passed.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

   typedef enum logic [1:0] {
      MODE_ONCE   = 2'b00,
      MODE_PERIOD = 2'b01,
      MODE_TOGGLE = 2'b10,
      MODE_FREE   = 2'b11
   } tmode_e;

endpackage

// File: rtl/ptimer_evsync.sv
module ptimer_evsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ptimer_evsync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);
   generate
      if (PRE_W < 1) begin : g_bad
         $error("ptimer_prescale needs PRE_W >= 1");
      end
   endgenerate

   logic [PRE_W-1:0] pcnt_q;
   logic             wrap;

   assign wrap = (pcnt_q == div);
   assign tick = run & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pcnt_q <= '0;
      else if (clr)      pcnt_q <= '0;
      else if (run) begin
         if (wrap)       pcnt_q <= '0;
         else            pcnt_q <= pcnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ptimer_core.sv
module ptimer_core
   import ptimer_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  tmode_e           mode,
   input  logic [CNT_W-1:0] cmp,
   input  logic             en_wr,
   input  logic             en_wdata,
   input  logic             irq_en,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             en,
   output logic             irq,
   output logic             tout
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             en_q, irq_q, tout_q;
   logic             adv, hit, restart;

   assign adv     = step & en_q;
   assign cnt_nxt = cnt_q + 1'b1;
   assign hit     = adv & (cnt_nxt == cmp);
   assign restart = hit & (mode != MODE_FREE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           en_q <= 1'b0;
      else if (clr)                         en_q <= 1'b0;
      else if (hit && mode == MODE_ONCE)    en_q <= 1'b0;
      else if (en_wr)                       en_q <= en_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else if (adv)      cnt_q <= cnt_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 irq_q <= 1'b0;
      else if (hit && irq_en)     irq_q <= 1'b1;
      else if (irq_clr)           irq_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           tout_q <= 1'b0;
      else if (clr)                         tout_q <= 1'b0;
      else if (hit && mode == MODE_TOGGLE)  tout_q <= ~tout_q;
   end

   assign cnt  = cnt_q;
   assign en   = en_q;
   assign irq  = irq_q;
   assign tout = tout_q;

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
   import ptimer_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             en_wdata,
   input  logic             sw_rst,
   input  logic [1:0]       mode,
   input  logic [PRE_W-1:0] presc,
   input  logic [CNT_W-1:0] cmp,
   input  logic             irq_en,
   input  logic             irq_clr,
   input  logic             load_en,
   input  logic             evt_mode,
   input  logic             evt_in,
   output logic             active,
   output logic [CNT_W-1:0] cnt_data,
   output logic             irq,
   output logic             tout
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("ptimer_top: CNT_W out of range");
      end
   endgenerate

   logic             en;
   logic             pre_tick;
   logic             evt_rise;
   logic             step;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] data_q;

   ptimer_evsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (evt_in),
      .rise     (evt_rise)
   );

   ptimer_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sw_rst),
      .run   (en & ~evt_mode),
      .div   (presc),
      .tick  (pre_tick)
   );

   assign step = evt_mode ? evt_rise : pre_tick;

   ptimer_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sw_rst),
      .step     (step),
      .mode     (tmode_e'(mode)),
      .cmp      (cmp),
      .en_wr    (en_wr),
      .en_wdata (en_wdata),
      .irq_en   (irq_en),
      .irq_clr  (irq_clr),
      .cnt      (cnt_q),
      .en       (en),
      .irq      (irq),
      .tout     (tout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (load_en) data_q <= cnt_q;
   end

   assign active   = en;
   assign cnt_data = data_q;

endmodule

// File: rtl/ptimer_chk.sv
module ptimer_chk #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_rst,
   input logic             en_wr,
   input logic             load_en,
   input logic [1:0]       mode,
   input logic             irq_clr,
   input logic             active,
   input logic [CNT_W-1:0] cnt_data,
   input logic             irq,
   input logic             tout,
   input logic [CNT_W-1:0] cnt_q
);
   p_swrst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (!active && cnt_q == '0));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !en_wr && !sw_rst) |=> $stable(cnt_q));

   p_data_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (cnt_data == $past(cnt_q)));

   p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(cnt_data));

   p_tout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b10 && !sw_rst) |=> $stable(tout));

   p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

endmodule

bind ptimer_top ptimer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sw_rst   (sw_rst),
   .en_wr    (en_wr),
   .load_en  (load_en),
   .mode     (mode),
   .irq_clr  (irq_clr),
   .active   (active),
   .cnt_data (cnt_data),
   .irq      (irq),
   .tout     (tout),
   .cnt_q    (cnt_q)
);

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_wr = 1'b0, en_wdata = 1'b0, sw_rst = 1'b0;
   logic [1:0]  mode = 2'b01;
   logic [7:0]  presc = '0;
   logic [23:0] cmp = '0;
   logic        irq_en = 1'b0, irq_clr = 1'b0, load_en = 1'b0;
   logic        evt_mode = 1'b0, evt_in = 1'b0;
   logic        active, irq, tout;
   logic [23:0] cnt_data;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ptimer_top u_dut (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
      .sw_rst(sw_rst), .mode(mode), .presc(presc), .cmp(cmp),
      .irq_en(irq_en), .irq_clr(irq_clr), .load_en(load_en),
      .evt_mode(evt_mode), .evt_in(evt_in), .active(active),
      .cnt_data(cnt_data), .irq(irq), .tout(tout)
   );

   typedef struct packed {
      logic [7:0]  p;
      logic [23:0] c;
      logic [1:0]  md;
      logic [15:0] m;
      logic [23:0] d;
      logic        q;
      logic        e;
      logic        t;
   } vec_t;

   // presc, cmp, mode, edges after enable, expected data/irq/active/tout
   localparam vec_t VECS [8] = '{
      '{8'd0, 24'd5, 2'b01, 16'd3,  24'd2, 1'b0, 1'b1, 1'b0},
      '{8'd0, 24'd5, 2'b01, 16'd7,  24'd1, 1'b1, 1'b1, 1'b0},
      '{8'd3, 24'd4, 2'b01, 16'd10, 24'd2, 1'b0, 1'b1, 1'b0},
      '{8'd1, 24'd3, 2'b00, 16'd9,  24'd0, 1'b1, 1'b0, 1'b0},
      '{8'd0, 24'd8, 2'b00, 16'd5,  24'd4, 1'b0, 1'b1, 1'b0},
      '{8'd0, 24'd4, 2'b11, 16'd10, 24'd9, 1'b1, 1'b1, 1'b0},
      '{8'd0, 24'd0, 2'b11, 16'd6,  24'd5, 1'b0, 1'b1, 1'b0},
      '{8'd2, 24'd2, 2'b10, 16'd10, 24'd1, 1'b1, 1'b1, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic start_run(input logic [7:0] p, input logic [23:0] c, input logic [1:0] md);
      @(negedge clk);
      sw_rst = 1'b1; irq_clr = 1'b1;
      presc = p; cmp = c; mode = md;
      load_en = 1'b1; irq_en = 1'b1; evt_mode = 1'b0;
      @(negedge clk);
      sw_rst = 1'b0; irq_clr = 1'b0; en_wr = 1'b1; en_wdata = 1'b1;
      @(negedge clk);
      en_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 active", active, 0);
      chk("R1 cnt_data", cnt_data, 0);
      chk("R1 irq", irq, 0);
      chk("R1 tout", tout, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table: R2 prescale, R7 periodic, R8 toggle, R9 continuous, R10 one-shot
      foreach (VECS[i]) begin
         start_run(VECS[i].p, VECS[i].c, VECS[i].md);
         repeat (int'(VECS[i].m)) @(negedge clk);
         chk($sformatf("R2/R7-R10 vec%0d data", i), cnt_data, VECS[i].d);
         chk($sformatf("R11 vec%0d irq", i), irq, VECS[i].q);
         chk($sformatf("R4/R10 vec%0d active", i), active, VECS[i].e);
         chk($sformatf("R8 vec%0d tout", i), tout, VECS[i].t);
      end

      // R6: mirror follows then holds
      start_run(8'd0, 24'd1000, 2'b01);
      repeat (4) @(negedge clk);
      chk("R6 follow", cnt_data, 3);
      load_en = 1'b0;
      repeat (6) @(negedge clk);
      chk("R6 hold", cnt_data, 3);
      load_en = 1'b1;
      @(negedge clk);
      chk("R6 resume", cnt_data, 10);

      // R3: software reset overrides enable write
      sw_rst = 1'b1; en_wr = 1'b1; en_wdata = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0; en_wr = 1'b0;
      chk("R3 active", active, 0);
      @(negedge clk);
      chk("R3 count zero", cnt_data, 0);
      // R4: no movement while disabled
      repeat (5) @(negedge clk);
      chk("R4 idle count", cnt_data, 0);

      // R5: event counting
      start_run(8'd0, 24'd1000, 2'b01);
      evt_mode = 1'b1;
      sw_rst = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0; en_wr = 1'b1;
      @(negedge clk);
      en_wr = 1'b0;
      repeat (10) @(negedge clk);
      chk("R5 no clock steps", cnt_data, 0);
      for (int k = 0; k < 4; k++) begin
         evt_in = 1'b1; repeat (3) @(negedge clk);
         evt_in = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (5) @(negedge clk);
      chk("R5 event count", cnt_data, 4);
      evt_mode = 1'b0;

      // R11: disabled flag, then sticky and clear
      start_run(8'd0, 24'd2, 2'b01);
      irq_en = 1'b0;
      repeat (10) @(negedge clk);
      chk("R11 masked", irq, 0);
      irq_en = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 set", irq, 1);
      en_wr = 1'b1; en_wdata = 1'b0;
      @(negedge clk);
      en_wr = 1'b0;
      repeat (4) @(negedge clk);
      chk("R11 sticky", irq, 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R11 cleared", irq, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule